// File: doc/BRIEF.md
# SPI Transfer Shifter with Delayed Sampling

This block runs SPI transfer commands for a host that feeds it 16-bit command words through a valid/ready handshake. For each transfer command it lowers the chip-select, produces a divided serial clock, sends transmit words MSB first on the serial output, and shifts in one bit per serial clock on each of several input lanes. A received word, with all lanes side by side, is presented on a wide output bus together with a one-cycle valid strobe.

The write and read enables of a transfer are copied into registers when its command is accepted. They then stay fixed until the next transfer command, so the host may already be presenting a different command while the current one runs. The moment at which the input lanes are captured can be pushed back by a whole number of core cycles after the nominal sampling point to absorb board and pad round-trip delay. The command handshake stays closed until that delayed capture of the final bit has happened, so the strobe for the last word is never dropped.

Top module: `spi_xfer_shifter`

## Requirements
- R1: A command word whose bits 15:12 are not all zero is accepted in one cycle while ready is high and is otherwise ignored: chip-select stays high, serial clock stays low and the handshake stays ready.
- R2: A command with bits 15:12 equal to zero is a transfer; its bit 9 (write enable) and bit 8 (read enable) are latched on acceptance, and any later value on the command bus has no effect on that transfer.
- R3: Bits 7:0 of a transfer give the word count minus one. Chip-select goes low from the cycle after acceptance for exactly (count) x DATA_W x 2 x (CLK_DIV+1) cycles; the serial clock idles low, has period 2 x (CLK_DIV+1) core cycles and is high in the second half of each bit.
- R4: With the write enable set, each word is taken from the transmit input (word 0 in the acceptance cycle, each following word in the last cycle of the previous one, each marked by a one-cycle load strobe) and sent MSB first; the serial output is held low when the write enable is clear or no transfer runs.
- R5: Each lane is captured at the clock edge that closes core cycle s + SDI_DELAY, where s is the last cycle before the serial clock rises; bits enter MSB first.
- R6: With the read enable set, after the final bit of each word is captured the output bus shows lane n in bits [n x DATA_W +: DATA_W] and the valid strobe is high for exactly the next cycle; with the read enable clear no strobe appears and the bus keeps its old value.
- R7: The valid strobe of the last word fires even when its delayed capture lands after the serial clock has stopped and a new command is already waiting on the bus.
- R8: Command ready is low from the acceptance of a transfer until the transfer has ended and the last delayed capture has been made; it returns high in the cycle after both.
- R9: After reset chip-select is high, the serial clock and output are low, no strobe is asserted, the output bus is zero and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command word is present |
| cmdReady | output | 1 | Block can take a command this cycle |
| cmdWord | input | 16 | Command word |
| txData | input | DATA_W | Transmit word, sampled when txLoad is high |
| txLoad | output | 1 | Transmit word taken this cycle |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip-select, active low |
| sdo | output | 1 | Serial data out |
| sdi | input | LANES | Serial data in, one bit per lane |
| rxData | output | LANES x DATA_W | Last received word, lanes side by side |
| rxValid | output | 1 | One-cycle strobe for a new rxData |

## Verification
A divider or bit counter that is off by one shows within one serial-clock period as a wrong sclk or sdo level and as a chip-select window of the wrong length. A delay pipeline of the wrong depth captures a neighbouring bit, because the bench changes each lane value exactly SDI_DELAY cycles after the nominal point; the error shows on rxData at the end of the first word. A read flag that is not held, or a ready that opens before the final delayed capture, shows as a missing or extra valid strobe on the last word of a transfer that is followed by a waiting command.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  localparam int CMD_W       = 16;
  localparam int TYPE_LO     = 12;
  localparam int WR_BIT      = 9;
  localparam int RD_BIT      = 8;
  localparam int COUNT_W     = 8;

  typedef struct packed {
    logic active;       // transfer in progress
    logic loadWord;     // take txData into the transmit shifter
    logic shiftBit;     // advance the transmit shifter by one bit
    logic capture;      // delayed sample point for the input lanes
    logic captureLast;  // the delayed sample is the last bit of a word
    logic wrFlag;       // latched write enable
    logic rdFlag;       // latched read enable
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CLK_DIV   = 1,
  parameter int SDI_DELAY = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [CMD_W-1:0] cmdWord,
  output logic             txLoad,
  output logic             sclk,
  output logic             csN,
  output ctrlStrobes_t     strb
);

  localparam int CNT_W = (CLK_DIV > 0) ? $clog2(CLK_DIV + 1) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic               active;
  logic               phase;
  logic [CNT_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [COUNT_W-1:0] wordsLeft;
  logic               wrEnQ;
  logic               rdEnQ;
  logic               pipeEmpty;
  logic               capNow;
  logic               capLast;

  logic isXfer, acceptXfer, tick, lastBit, bitEnd, wordEnd, xferEnd;
  logic nominal, nominalLast;
  logic unusedCmdBits;

  assign unusedCmdBits = ^cmdWord[TYPE_LO-1:WR_BIT+1];

  assign isXfer      = (cmdWord[CMD_W-1:TYPE_LO] == '0);
  assign cmdReady    = !active && pipeEmpty;
  assign acceptXfer  = cmdValid && cmdReady && isXfer;
  assign tick        = (divCnt == CNT_W'(CLK_DIV));
  assign lastBit     = (bitCnt == BIT_W'(DATA_W - 1));
  assign bitEnd      = active && tick && phase;
  assign wordEnd     = bitEnd && lastBit && (wordsLeft != '0);
  assign xferEnd     = bitEnd && lastBit && (wordsLeft == '0);
  assign nominal     = active && tick && !phase;
  assign nominalLast = nominal && lastBit;

  // Bit timing and transfer state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phase     <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      wordsLeft <= '0;
      wrEnQ     <= 1'b0;
      rdEnQ     <= 1'b0;
    end else if (acceptXfer) begin
      active    <= 1'b1;
      phase     <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      wordsLeft <= cmdWord[COUNT_W-1:0];
      wrEnQ     <= cmdWord[WR_BIT];
      rdEnQ     <= cmdWord[RD_BIT];
    end else if (active) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) phase <= !phase;
      if (bitEnd) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (wordEnd) wordsLeft <= wordsLeft - 1'b1;
      if (xferEnd) active <= 1'b0;
    end
  end

  // Delay line that carries the sample point towards the capture edge
  generate
    if (SDI_DELAY == 0) begin : g_noDelay
      assign capNow    = nominal;
      assign capLast   = nominalLast;
      assign pipeEmpty = 1'b1;
    end else begin : g_delay
      logic [SDI_DELAY-1:0] pipeV;
      logic [SDI_DELAY-1:0] pipeL;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeV <= '0;
          pipeL <= '0;
        end else begin
          pipeV[0] <= nominal;
          pipeL[0] <= nominalLast;
          for (int i = 1; i < SDI_DELAY; i++) begin
            pipeV[i] <= pipeV[i-1];
            pipeL[i] <= pipeL[i-1];
          end
        end
      end
      assign capNow    = pipeV[SDI_DELAY-1];
      assign capLast   = pipeL[SDI_DELAY-1];
      assign pipeEmpty = (pipeV == '0);
    end
  endgenerate

  assign txLoad = (acceptXfer && cmdWord[WR_BIT]) || (wordEnd && wrEnQ);
  assign sclk   = active && phase;
  assign csN    = !active;

  always_comb begin
    strb.active      = active;
    strb.loadWord    = acceptXfer || wordEnd;
    strb.shiftBit    = bitEnd && !lastBit;
    strb.capture     = capNow;
    strb.captureLast = capLast;
    strb.wrFlag      = wrEnQ;
    strb.rdFlag      = rdEnQ;
  end

endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [DATA_W-1:0]       txData,
  input  logic [LANES-1:0]        sdi,
  output logic                    sdo,
  output logic [LANES*DATA_W-1:0] rxData,
  output logic                    rxValid
);

  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadWord) begin
      txShift <= txData;
    end else if (strb.shiftBit) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = strb.active && strb.wrFlag && txShift[DATA_W-1];

  generate
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
      logic [DATA_W-2:0] rxShift;
      logic [DATA_W-1:0] nextWord;
      assign nextWord = {rxShift, sdi[lane]};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rxShift                          <= '0;
          rxData[lane*DATA_W +: DATA_W]    <= '0;
        end else if (strb.capture) begin
          rxShift <= nextWord[DATA_W-2:0];
          if (strb.captureLast && strb.rdFlag)
            rxData[lane*DATA_W +: DATA_W] <= nextWord;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxValid <= 1'b0;
    else       rxValid <= strb.capture && strb.captureLast && strb.rdFlag;
  end

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LANES     = 2,
  parameter int CLK_DIV   = 1,
  parameter int SDI_DELAY = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  output logic                    cmdReady,
  input  logic [15:0]             cmdWord,
  input  logic [DATA_W-1:0]       txData,
  output logic                    txLoad,
  output logic                    sclk,
  output logic                    csN,
  output logic                    sdo,
  input  logic [LANES-1:0]        sdi,
  output logic [LANES*DATA_W-1:0] rxData,
  output logic                    rxValid
);

  ctrlStrobes_t strb;

  spi_xfer_ctrl #(
    .DATA_W    (DATA_W),
    .CLK_DIV   (CLK_DIV),
    .SDI_DELAY (SDI_DELAY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdReady (cmdReady),
    .cmdWord  (cmdWord),
    .txLoad   (txLoad),
    .sclk     (sclk),
    .csN      (csN),
    .strb     (strb)
  );

  spi_xfer_dp #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txData  (txData),
    .sdi     (sdi),
    .sdo     (sdo),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: rtl/spi_xfer_shifter_chk.sv
module spi_xfer_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic sdo,
  input logic cmdReady,
  input logic rxValid,
  input logic wrFlag,
  input logic rdFlag
);

  p_sclk_low_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_ready_low_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !cmdReady);

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && $past(!cmdReady)) |-> ($stable(wrFlag) && $stable(rdFlag)));

  p_sdo_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlag |-> !sdo);

  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_rx_needs_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> rdFlag);

endmodule

bind spi_xfer_shifter spi_xfer_shifter_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .sclk     (sclk),
  .sdo      (sdo),
  .cmdReady (cmdReady),
  .rxValid  (rxValid),
  .wrFlag   (strb.wrFlag),
  .rdFlag   (strb.rdFlag)
);

// File: tb/spi_xfer_shifter_tb.sv
module spi_xfer_shifter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int LN  = 2;
  localparam int DIV = 1;
  localparam int DLY = 3;
  localparam int H   = DIV + 1;
  localparam int BP  = 2 * H;
  localparam int WP  = DW * BP;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic             cmdReady;
  logic [15:0]      cmdWord = '0;
  logic [DW-1:0]    txData = '0;
  logic             txLoad;
  logic             sclk, csN, sdo;
  logic [LN-1:0]    sdi = '0;
  logic [LN*DW-1:0] rxData;
  logic             rxValid;

  spi_xfer_shifter #(
    .DATA_W(DW), .LANES(LN), .CLK_DIV(DIV), .SDI_DELAY(DLY)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWord(cmdWord), .txData(txData), .txLoad(txLoad), .sclk(sclk),
    .csN(csN), .sdo(sdo), .sdi(sdi), .rxData(rxData), .rxValid(rxValid)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  string phaseTag = "R9";

  // reference model state
  int mBusy = 0, mStart = 0, mLen = 0, mWr = 0, mRd = 0, bank = 0;
  logic [DW-1:0]    txPat [2][16];
  logic [DW-1:0]    rxPat [2][LN][16];
  logic [DW-1:0]    pendTx0 = '0;
  logic [LN*DW-1:0] expRx = '0;
  logic [15:0]      lfsr = 16'hACE1;

  function automatic logic [DW-1:0] nextRand();
    for (int i = 0; i < DW; i++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[DW-1:0];
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", phaseTag, what, act, exp, cyc);
    end
  endtask

  // one clock of the reference model, compared at the falling edge
  task automatic step();
    logic eCs, eSclk, eSdo, eLoad, eRv, eRdy;
    @(negedge clk);
    cyc++;
    eCs = 1; eSclk = 0; eSdo = 0; eLoad = 0; eRv = 0; eRdy = 1;
    if (mBusy != 0) begin
      int k, T, rk, r;
      k  = cyc - mStart;
      T  = (mLen + 1) * WP;
      rk = T + ((DLY > H) ? DLY - H : 0);
      if (k < T) begin
        int w, bi;
        w  = k / WP;
        bi = DW - 1 - ((k % WP) / BP);
        eCs   = 0;
        eSclk = ((k % BP) >= H);
        eSdo  = (mWr != 0) && txPat[bank][w][bi];
        eLoad = (mWr != 0) && ((k % WP) == WP - 1) && (k != T - 1);
      end
      r = k - DLY - 1 - ((DW - 1) * BP + H - 1);
      if ((mRd != 0) && r >= 0 && (r % WP) == 0 && (r / WP) <= mLen) begin
        eRv = 1;
        for (int l = 0; l < LN; l++) expRx[l*DW +: DW] = rxPat[bank][l][r / WP];
      end
      eRdy = (k >= rk);
      if (k >= rk) begin
        mBusy = 0;
      end else begin
        int j, g, ti;
        j = k - DLY - (H - 1);
        g = (j < 0) ? 0 : j / BP;
        if (g > (mLen + 1) * DW - 1) g = (mLen + 1) * DW - 1;
        for (int l = 0; l < LN; l++) sdi[l] = rxPat[bank][l][g / DW][DW - 1 - (g % DW)];
        ti = (k + 1) / WP;
        if (ti > mLen) ti = mLen;
        txData = txPat[bank][ti];
      end
    end
    if (mBusy == 0) begin
      sdi    = '0;
      txData = pendTx0;
    end
    if (eRdy && cmdValid && cmdWord[15:12] == 4'h0 && cmdWord[9]) eLoad = 1;
    check("R3 csN", 64'(csN), 64'(eCs));
    check("R3 sclk", 64'(sclk), 64'(eSclk));
    check("R4 sdo", 64'(sdo), 64'(eSdo));
    check("R4 txLoad", 64'(txLoad), 64'(eLoad));
    check("R6 rxValid", 64'(rxValid), 64'(eRv));
    check("R5 rxData", 64'(rxData), 64'(expRx));
    check("R8 cmdReady", 64'(cmdReady), 64'(eRdy));
  endtask

  task automatic sendCmd(input logic [15:0] cmd);
    int pb;
    pb = 1 - bank;
    cmdWord  = cmd;
    cmdValid = 1'b1;
    if (cmd[15:12] == 4'h0) begin
      for (int w = 0; w < 16; w++) begin
        txPat[pb][w] = nextRand();
        for (int l = 0; l < LN; l++) rxPat[pb][l][w] = nextRand();
      end
      pendTx0 = txPat[pb][0];
      if (mBusy == 0) txData = pendTx0;
    end
    while (!cmdReady) step();
    if (cmd[15:12] == 4'h0) begin
      mBusy  = 1;
      mStart = cyc + 1;
      mLen   = int'(cmd[7:0]);
      mWr    = int'(cmd[9]);
      mRd    = int'(cmd[8]);
      bank   = pb;
    end
    step();
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (mBusy != 0) step();
    repeat (3) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R8: actual hung expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R9: reset state
    phaseTag = "R9";
    repeat (4) step();
    rstN = 1'b1;
    repeat (2) step();

    // R2 and R7: write+read, three words, with a different command waiting
    phaseTag = "R2/R7";
    sendCmd(16'h0302);
    sendCmd(16'h0100);   // waits on the bus for the whole first transfer
    waitIdle();

    // R1: non-transfer command is accepted and ignored
    phaseTag = "R1";
    sendCmd(16'h1302);
    for (int i = 0; i < 12; i++) begin
      step();
      check("R1 csN stays high", 64'(csN), 64'd1);
    end

    // R6: write-only, read data must hold
    phaseTag = "R6";
    sendCmd(16'h0201);
    waitIdle();

    // R4: neither enable, sdo low and no strobe
    phaseTag = "R4";
    sendCmd(16'h0000);
    waitIdle();

    // R3/R5: longer read+write transfer, then back-to-back read-only
    phaseTag = "R3/R5";
    sendCmd(16'h0304);
    sendCmd(16'h0101);
    waitIdle();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule